// File: doc/BRIEF.md
# Current Fault Auto-Retry Latch

This block decides what happens to the charge and discharge switch enables of a battery pack after a current fault such as a short circuit or an overcurrent. Each fault type arrives as a one-cycle pulse. Two per-type masks say which switch each type turns off. After a programmed number of timebase ticks, the block turns the switches back on without any help from the host.

Consecutive faults are counted. A fault counts as consecutive when it follows a re-enable before the switches have stayed on for one full recovery interval. When the count reaches the configured limit, the block stops retrying. It then holds the switches off and reports a latched condition. Only a host recovery pulse releases that condition.

The block sits between the fault detectors and the switch drivers. Configuration comes from static settings inputs, and a slow tick of nominally one second paces all timing.

Top module: `cur_fault_retry`

## Requirements
- R1: When fault type i pulses, the discharge enable goes low if bit i of `dsg_mask_i` is set, and the charge enable goes low if bit i of `chg_mask_i` is set. The change shows in the cycle after the clock edge that samples the pulse.
- R2: While recovery is pending, the switches turn back on at the edge that samples tick number max(`recov_time_i`,1) after the last fault. Both enables then read 1.
- R3: A fault during a pending recovery restarts the delay from zero. It adds its own switches to those already off, and it does not advance the retry count.
- R4: A fault pulse on a type with neither mask bit set is ignored. It does not change the enables, it does not restart a delay and it does not advance the retry count.
- R5: When the retry count reaches a nonzero `latch_lim_i`, the block enters the latched state. `latched_o` reads 1, the affected switches stay off whatever ticks arrive, and further faults are ignored.
- R6: A `latch_lim_i` of 0 never latches, so retries continue without limit.
- R7: The retry count returns to zero once the switches have stayed on for max(`recov_time_i`,1) ticks with no fault. The next fault then counts as the first.
- R8: A `host_recover_i` pulse clears the latched state and the count and turns both switches on in the next cycle. It wins over a fault in the same cycle.
- R9: A fault in the same cycle as the tick that would end a delay keeps the switches off and restarts the delay. A fault in the same cycle as the tick that would end the clean-on interval still counts as consecutive.
- R10: After reset, both enables read 1 and `latched_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | NUM_FAULT | One-cycle fault pulse per fault type |
| dsg_mask_i | input | NUM_FAULT | Per type: fault turns the discharge switch off |
| chg_mask_i | input | NUM_FAULT | Per type: fault turns the charge switch off |
| recov_time_i | input | TIME_W | Recovery delay and clean-on interval in ticks |
| latch_lim_i | input | LIM_W | Retry limit; 0 means unlimited |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| host_recover_i | input | 1 | Host recovery command, one cycle wide |
| dsg_en_o | output | 1 | Discharge switch enable |
| chg_en_o | output | 1 | Charge switch enable |
| latched_o | output | 1 | Retry limit reached, switches held |

## Verification
Two functions can land on the same edge: a fault pulse and the tick that ends a timer. There are two such timers, the recovery delay and the clean-on interval that clears the count. The bench provokes both cases by raising the fault and the tick in the same cycle when the remaining time is one tick. In the first case it checks that the switches stay off and that a fresh full delay follows. In the second case, with a limit of two, it checks that the block latches. The bench also pairs the host command with a fault in one cycle and checks that the enables come back on and the block is not latched.

// File: rtl/cur_fault_retry_pkg.sv
package cur_fault_retry_pkg;
   typedef enum logic [1:0] {
      ST_ON      = 2'd0,
      ST_WAIT    = 2'd1,
      ST_LATCHED = 2'd2
   } retry_state_e;

   typedef struct packed {
      logic dsg;
      logic chg;
   } sw_pair_t;
endpackage

// File: rtl/cfr_fault_reduce.sv
module cfr_fault_reduce
   import cur_fault_retry_pkg::*;
#(
   parameter int NUM_FAULT = 3
) (
   input  logic [NUM_FAULT-1:0] fault_i,
   input  logic [NUM_FAULT-1:0] dsg_mask_i,
   input  logic [NUM_FAULT-1:0] chg_mask_i,
   output sw_pair_t             hit_o,
   output logic                 any_o
);
   logic [NUM_FAULT-1:0] dsg_hit;
   logic [NUM_FAULT-1:0] chg_hit;

   for (genvar g = 0; g < NUM_FAULT; g++) begin : g_type
      assign dsg_hit[g] = fault_i[g] & dsg_mask_i[g];
      assign chg_hit[g] = fault_i[g] & chg_mask_i[g];
   end

   assign hit_o.dsg = |dsg_hit;
   assign hit_o.chg = |chg_hit;
   assign any_o     = hit_o.dsg | hit_o.chg;
endmodule

// File: rtl/cfr_tick_timer.sv
module cfr_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   output logic         expire_o,
   output logic         active_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic         act_q;

   assign expire_o = act_q & tick_i & (cnt_q <= ONE);
   assign active_o = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         act_q <= 1'b1;
      end else if (act_q && tick_i) begin
         if (cnt_q <= ONE) begin
            cnt_q <= '0;
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/cfr_retry_count.sv
module cfr_retry_count #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   input  logic [W-1:0] limit_i,
   output logic         limit_hit_o
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nx;

   assign cnt_nx      = (cnt_q == MAXV) ? MAXV : cnt_q + W'(1);
   assign limit_hit_o = (limit_i != '0) && (cnt_nx >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/cur_fault_retry.sv
module cur_fault_retry
   import cur_fault_retry_pkg::*;
#(
   parameter int NUM_FAULT = 3,
   parameter int TIME_W    = 8,
   parameter int LIM_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FAULT-1:0] fault_i,
   input  logic [NUM_FAULT-1:0] dsg_mask_i,
   input  logic [NUM_FAULT-1:0] chg_mask_i,
   input  logic [TIME_W-1:0]    recov_time_i,
   input  logic [LIM_W-1:0]     latch_lim_i,
   input  logic                 tick_i,
   input  logic                 host_recover_i,
   output logic                 dsg_en_o,
   output logic                 chg_en_o,
   output logic                 latched_o
);
   if (NUM_FAULT < 1) begin : g_bad_nf
      $error("NUM_FAULT must be at least 1");
   end
   if (TIME_W < 1 || TIME_W > 16) begin : g_bad_tw
      $error("TIME_W out of range");
   end
   if (LIM_W < 1 || LIM_W > 8) begin : g_bad_lw
      $error("LIM_W out of range");
   end

   retry_state_e state_q, state_d;
   sw_pair_t     off_q, off_d;
   sw_pair_t     hit;
   logic         hit_any;
   logic         wait_clr, wait_ld, wait_exp, wait_act;
   logic         grd_clr, grd_ld, grd_exp, grd_act;
   logic         cnt_clr, cnt_inc, lim_hit;

   cfr_fault_reduce #(.NUM_FAULT(NUM_FAULT)) u_reduce (
      .fault_i    (fault_i),
      .dsg_mask_i (dsg_mask_i),
      .chg_mask_i (chg_mask_i),
      .hit_o      (hit),
      .any_o      (hit_any)
   );

   cfr_tick_timer #(.W(TIME_W)) u_wait_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (wait_clr),
      .load_i     (wait_ld),
      .load_val_i (recov_time_i),
      .tick_i     (tick_i),
      .expire_o   (wait_exp),
      .active_o   (wait_act)
   );

   cfr_tick_timer #(.W(TIME_W)) u_guard_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (grd_clr),
      .load_i     (grd_ld),
      .load_val_i (recov_time_i),
      .tick_i     (tick_i),
      .expire_o   (grd_exp),
      .active_o   (grd_act)
   );

   cfr_retry_count #(.W(LIM_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (cnt_clr),
      .inc_i       (cnt_inc),
      .limit_i     (latch_lim_i),
      .limit_hit_o (lim_hit)
   );

   always_comb begin
      state_d  = state_q;
      off_d    = off_q;
      wait_clr = 1'b0;
      wait_ld  = 1'b0;
      grd_clr  = 1'b0;
      grd_ld   = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      if (host_recover_i) begin
         state_d  = ST_ON;
         off_d    = '0;
         wait_clr = 1'b1;
         grd_clr  = 1'b1;
         cnt_clr  = 1'b1;
      end else begin
         unique case (state_q)
            ST_ON: begin
               if (hit_any) begin
                  cnt_inc   = 1'b1;
                  grd_clr   = 1'b1;
                  off_d.dsg = off_q.dsg | hit.dsg;
                  off_d.chg = off_q.chg | hit.chg;
                  if (lim_hit) begin
                     state_d  = ST_LATCHED;
                     wait_clr = 1'b1;
                  end else begin
                     state_d = ST_WAIT;
                     wait_ld = 1'b1;
                  end
               end else if (grd_exp && grd_act) begin
                  cnt_clr = 1'b1;
               end
            end
            ST_WAIT: begin
               if (hit_any) begin
                  off_d.dsg = off_q.dsg | hit.dsg;
                  off_d.chg = off_q.chg | hit.chg;
                  wait_ld   = 1'b1;
               end else if (wait_exp && wait_act) begin
                  state_d = ST_ON;
                  off_d   = '0;
                  grd_ld  = 1'b1;
               end
            end
            ST_LATCHED: begin
               state_d = ST_LATCHED;
            end
            default: begin
               state_d = ST_ON;
               off_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ON;
         off_q   <= '0;
      end else begin
         state_q <= state_d;
         off_q   <= off_d;
      end
   end

   assign dsg_en_o  = ~off_q.dsg;
   assign chg_en_o  = ~off_q.chg;
   assign latched_o = (state_q == ST_LATCHED);
endmodule

// File: rtl/cur_fault_retry_chk.sv
module cur_fault_retry_chk #(
   parameter int NUM_FAULT = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_FAULT-1:0] fault_i,
   input logic [NUM_FAULT-1:0] dsg_mask_i,
   input logic [NUM_FAULT-1:0] chg_mask_i,
   input logic                 tick_i,
   input logic                 host_recover_i,
   input logic                 dsg_en_o,
   input logic                 chg_en_o,
   input logic                 latched_o
);
   // R8
   host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_recover_i |=> (dsg_en_o && chg_en_o && !latched_o));

   // R5
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_o && !host_recover_i) |=> (latched_o && $stable(dsg_en_o) && $stable(chg_en_o)));

   // R1
   dsg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(fault_i & dsg_mask_i)) && !host_recover_i && !latched_o) |=> !dsg_en_o);

   // R1
   chg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(fault_i & chg_mask_i)) && !host_recover_i && !latched_o) |=> !chg_en_o);

   // R2
   reenable_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsg_en_o) |-> $past(tick_i || host_recover_i));

   // R4
   unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((fault_i & (dsg_mask_i | chg_mask_i)) == '0) && !tick_i && !host_recover_i)
      |=> ($stable(dsg_en_o) && $stable(chg_en_o) && $stable(latched_o)));
endmodule

bind cur_fault_retry cur_fault_retry_chk #(.NUM_FAULT(NUM_FAULT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fault_i        (fault_i),
   .dsg_mask_i     (dsg_mask_i),
   .chg_mask_i     (chg_mask_i),
   .tick_i         (tick_i),
   .host_recover_i (host_recover_i),
   .dsg_en_o       (dsg_en_o),
   .chg_en_o       (chg_en_o),
   .latched_o      (latched_o)
);

// File: tb/cur_fault_retry_tb_top.sv
module cur_fault_retry_tb_top;
   localparam int NF = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] fault = '0;
   logic [NF-1:0] dmask = 3'b101;
   logic [NF-1:0] cmask = 3'b110;
   logic [7:0]    rtime = 8'd2;
   logic [3:0]    lim = 4'd0;
   logic          tick = 1'b0;
   logic          host = 1'b0;
   logic          dsg_en, chg_en, latched;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cur_fault_retry #(.NUM_FAULT(NF), .TIME_W(8), .LIM_W(4)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .fault_i        (fault),
      .dsg_mask_i     (dmask),
      .chg_mask_i     (cmask),
      .recov_time_i   (rtime),
      .latch_lim_i    (lim),
      .tick_i         (tick),
      .host_recover_i (host),
      .dsg_en_o       (dsg_en),
      .chg_en_o       (chg_en),
      .latched_o      (latched)
   );

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {dsg,chg,latched} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic expect_out(input string req, input logic d, input logic c, input logic l);
      chk(req, {dsg_en, chg_en, latched}, {d, c, l});
   endtask

   // one clock cycle with the given inputs, ends on a falling edge
   task automatic step(input logic [NF-1:0] f, input logic t, input logic h);
      fault = f;
      tick  = t;
      host  = h;
      @(negedge clk);
      fault = '0;
      tick  = 1'b0;
      host  = 1'b0;
   endtask

   function automatic int ticks_of(input int t);
      return (t == 0) ? 1 : t;
   endfunction

   task automatic sweep(input int l, input int t);
      int n;
      lim   = 4'(l);
      rtime = 8'(t);
      step('0, 1'b0, 1'b1);
      expect_out("R8", 1, 1, 0);
      n = (l == 0) ? 4 : l;
      for (int k = 1; k <= n; k++) begin
         step(3'b001, 1'b0, 1'b0);
         if (l != 0 && k == l) begin
            expect_out("R5", 0, 1, 1);
            repeat (ticks_of(t) + 1) step('0, 1'b1, 1'b0);
            step(3'b010, 1'b0, 1'b0);
            expect_out("R5", 0, 1, 1);
         end else begin
            expect_out("R1", 0, 1, 0);
            repeat (ticks_of(t) - 1) step('0, 1'b1, 1'b0);
            expect_out("R2", 0, 1, 0);
            step('0, 1'b1, 1'b0);
            if (l == 0) expect_out("R6", 1, 1, 0);
            else        expect_out("R2", 1, 1, 0);
         end
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out("R10", 1, 1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R10", 1, 1, 0);

      // R2 R5 R6: sweep of limit and recovery time
      for (int l = 0; l <= 3; l++)
         for (int t = 0; t <= 3; t++)
            sweep(l, t);

      // R1: per-type masks
      lim = 4'd0; rtime = 8'd1;
      step('0, 1'b0, 1'b1);
      step(3'b010, 1'b0, 1'b0);
      expect_out("R1", 1, 0, 0);
      step('0, 1'b1, 1'b0);
      step(3'b100, 1'b0, 1'b0);
      expect_out("R1", 0, 0, 0);
      step('0, 1'b1, 1'b0);
      expect_out("R2", 1, 1, 0);

      // R4: unmasked type ignored, even with limit 1
      dmask = 3'b011; cmask = 3'b011; lim = 4'd1;
      step('0, 1'b0, 1'b1);
      step(3'b100, 1'b0, 1'b0);
      expect_out("R4", 1, 1, 0);
      step(3'b001, 1'b0, 1'b0);
      expect_out("R5", 0, 0, 1);
      dmask = 3'b101; cmask = 3'b110;

      // R3: restart of delay, OR of switches, no extra count
      lim = 4'd2; rtime = 8'd3;
      step('0, 1'b0, 1'b1);
      step(3'b001, 1'b0, 1'b0);
      step('0, 1'b1, 1'b0);
      step('0, 1'b1, 1'b0);
      step(3'b010, 1'b0, 1'b0);
      expect_out("R3", 0, 0, 0);
      step('0, 1'b1, 1'b0);
      step('0, 1'b1, 1'b0);
      expect_out("R3", 0, 0, 0);
      step('0, 1'b1, 1'b0);
      expect_out("R3", 1, 1, 0);
      step(3'b001, 1'b0, 1'b0);
      expect_out("R5", 0, 1, 1);

      // R7: count clears after a clean interval
      lim = 4'd2; rtime = 8'd2;
      step('0, 1'b0, 1'b1);
      step(3'b001, 1'b0, 1'b0);
      repeat (2) step('0, 1'b1, 1'b0);
      repeat (2) step('0, 1'b1, 1'b0);
      step(3'b001, 1'b0, 1'b0);
      expect_out("R7", 0, 1, 0);
      repeat (2) step('0, 1'b1, 1'b0);
      step('0, 1'b1, 1'b0);
      step(3'b001, 1'b0, 1'b0);
      expect_out("R7", 0, 1, 1);

      // R9: fault with the final delay tick
      lim = 4'd0; rtime = 8'd2;
      step('0, 1'b0, 1'b1);
      step(3'b001, 1'b0, 1'b0);
      step('0, 1'b1, 1'b0);
      step(3'b001, 1'b1, 1'b0);
      expect_out("R9", 0, 1, 0);
      step('0, 1'b1, 1'b0);
      expect_out("R9", 0, 1, 0);
      step('0, 1'b1, 1'b0);
      expect_out("R9", 1, 1, 0);

      // R9: fault with the final clean-on tick
      lim = 4'd2; rtime = 8'd1;
      step('0, 1'b0, 1'b1);
      step(3'b001, 1'b0, 1'b0);
      step('0, 1'b1, 1'b0);
      expect_out("R2", 1, 1, 0);
      step(3'b001, 1'b1, 1'b0);
      expect_out("R9", 0, 1, 1);

      // R8: host wins over a fault in the same cycle
      step(3'b100, 1'b0, 1'b1);
      expect_out("R8", 1, 1, 0);
      lim = 4'd1;
      step(3'b100, 1'b0, 1'b0);
      expect_out("R8", 0, 0, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule